// File: doc/BRIEF.md
# Strided Access Pattern Table

Each core carries a small table of access patterns that the compiler prepares and software loads. A pattern has a base offset, an access count (length) and a stride, and each of the three is written by its own command. Commands also claim a free slot and release a slot when the pattern is no longer needed. When a slot is claimed, the table reports which slot it gave out, or it reports an error when every slot is already in use.

The table watches the addresses of the core's misses. A miss address that equals the base offset of a fully defined pattern is a pattern hit. On a hit the table streams the addresses that the pattern covers over a valid/ready output, one address per cycle. Element k of the stream is base + 1 + k·(stride + 1), counted modulo 2^ADDR_W. The table takes no further lookups until the stream is finished. On a miss the table reports only the miss, and the caller issues an ordinary read. Cache arrays, coherence messages and the network are outside this block.

Top module: `stride_pattern_table`

## Requirements
- R1: After reset no slot is allocated, and lkHit, lkMiss, busy, specValid, specLast and rspValid are all 0. A lookup to any address on the empty table reports a miss.
- R2: A claim command (cmdOp = 0) sets rspValid one cycle later. If a slot is free, rspIdx is the lowest-numbered free slot, rspErr is 0 and that slot becomes allocated. If all N_ENTRIES slots are allocated, rspErr is 1 and no slot changes.
- R3: A slot can match only after its offset (cmdOp = 1), length (cmdOp = 2, low LEN_W bits of cmdData) and stride (cmdOp = 3) have all been written since it was last claimed. A partly defined slot gives a miss.
- R4: A lookup is accepted in a cycle where lkValid = 1 and busy = 0. One cycle after acceptance, exactly one of lkHit or lkMiss pulses for one cycle. lkHit pulses when lkAddr equals the offset of a matchable slot. On a miss specValid stays 0.
- R5: After a hit, specValid presents base + 1 + k·(stride + 1) mod 2^ADDR_W for k = 0 to length−1, in that order. The first address appears in the same cycle as lkHit, and specLast is 1 only with the final address.
- R6: While specValid = 1 and specReady = 0, specValid stays 1 and specAddr does not change.
- R7: busy is 1 from the lkHit cycle until the final address is accepted, and it is 0 in the next cycle. A lookup offered while busy = 1 gives neither lkHit nor lkMiss.
- R8: When several matchable slots hold the same offset, the lowest-numbered slot supplies the length and the stride.
- R9: A slot whose length is 0 never matches. A lookup to its offset reports a miss.
- R10: A release command (cmdOp = 4, slot in cmdIdx) makes that slot unallocated. Later lookups to its offset miss, and the next claim can return that slot.
- R11: Offset, length and stride writes addressed to a slot that is not allocated are ignored. Codes 5 to 7 on cmdOp do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command strobe |
| cmdOp | input | 3 | 0 claim, 1 offset, 2 length, 3 stride, 4 release |
| cmdIdx | input | IDX_W | Target slot for write and release commands |
| cmdData | input | ADDR_W | Value for offset, length or stride writes |
| rspValid | output | 1 | Claim response valid (one cycle after the claim) |
| rspIdx | output | IDX_W | Slot given out by the claim |
| rspErr | output | 1 | Claim failed because the table is full |
| lkValid | input | 1 | Miss address offered for lookup |
| lkAddr | input | ADDR_W | Miss address |
| lkHit | output | 1 | Lookup hit pulse |
| lkMiss | output | 1 | Lookup miss pulse |
| busy | output | 1 | Stream in progress, lookups refused |
| specValid | output | 1 | Speculative address valid |
| specReady | input | 1 | Consumer accepts specAddr |
| specAddr | output | ADDR_W | Speculative address |
| specLast | output | 1 | Final address of the stream |

## Verification
The case that is hardest to reach from the ports is a lookup offered in the middle of a stream that is stalled, and checking that this lookup gives no response at all. The bench reaches it by pulling specReady low at random during each stream and placing a lookup to a live trigger address in the second cycle of one stream. Duplicate triggers are the other hard case, and so are slots that are released and claimed again. The random phase draws offsets from only sixteen values, so collisions between slots are common and slots are often freed and reused between lookups.

// File: rtl/spt_pkg.sv
package spt_pkg;

  typedef enum logic [2:0] {
    OP_NEW    = 3'd0,
    OP_OFFSET = 3'd1,
    OP_LENGTH = 3'd2,
    OP_STRIDE = 3'd3,
    OP_FREE   = 3'd4
  } op_e;

  typedef struct packed {
    logic genStart;
    logic genStep;
    logic cmdNew;
    logic wrOff;
    logic wrLen;
    logic wrStr;
    logic doFree;
  } strobe_t;

endpackage

// File: rtl/spt_datapath.sv
module spt_datapath
  import spt_pkg::*;
#(
  parameter int N_ENTRIES = 8,
  parameter int ADDR_W    = 16,
  parameter int LEN_W     = 8,
  parameter int IDX_W     = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [IDX_W-1:0]  cmdIdx,
  input  logic [ADDR_W-1:0] cmdData,
  input  logic [ADDR_W-1:0] lkAddr,
  output logic [IDX_W-1:0]  freeIdx,
  output logic              tableFull,
  output logic              matchHit,
  output logic [ADDR_W-1:0] specAddr,
  output logic              lastElem
);

  logic              allocArr [N_ENTRIES];
  logic [ADDR_W-1:0] offArr   [N_ENTRIES];
  logic [LEN_W-1:0]  lenArr   [N_ENTRIES];
  logic [ADDR_W-1:0] strArr   [N_ENTRIES];
  logic [N_ENTRIES-1:0] matchVec;

  for (genvar i = 0; i < N_ENTRIES; i++) begin : gen_entry
    localparam logic [IDX_W-1:0] SLOT = IDX_W'(i);
    logic              allocQ, hasOffQ, hasLenQ, hasStrQ;
    logic [ADDR_W-1:0] offQ, strQ;
    logic [LEN_W-1:0]  lenQ;
    logic              target;

    assign target = allocQ && (cmdIdx == SLOT);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        allocQ  <= 1'b0;
        hasOffQ <= 1'b0;
        hasLenQ <= 1'b0;
        hasStrQ <= 1'b0;
        offQ    <= '0;
        lenQ    <= '0;
        strQ    <= '0;
      end else if (strb.cmdNew && freeIdx == SLOT) begin
        allocQ  <= 1'b1;
        hasOffQ <= 1'b0;
        hasLenQ <= 1'b0;
        hasStrQ <= 1'b0;
      end else if (strb.doFree && cmdIdx == SLOT) begin
        allocQ  <= 1'b0;
        hasOffQ <= 1'b0;
        hasLenQ <= 1'b0;
        hasStrQ <= 1'b0;
      end else if (target) begin
        if (strb.wrOff) begin
          offQ    <= cmdData;
          hasOffQ <= 1'b1;
        end
        if (strb.wrLen) begin
          lenQ    <= cmdData[LEN_W-1:0];
          hasLenQ <= 1'b1;
        end
        if (strb.wrStr) begin
          strQ    <= cmdData;
          hasStrQ <= 1'b1;
        end
      end
    end

    assign allocArr[i] = allocQ;
    assign offArr[i]   = offQ;
    assign lenArr[i]   = lenQ;
    assign strArr[i]   = strQ;
    assign matchVec[i] = allocQ && hasOffQ && hasLenQ && hasStrQ &&
                         (lenQ != '0) && (offQ == lkAddr);
  end

  // lowest free slot and lowest matching slot
  logic [IDX_W-1:0] matchIdx;
  always_comb begin
    freeIdx   = '0;
    tableFull = 1'b1;
    matchIdx  = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (!allocArr[i]) begin
        freeIdx   = IDX_W'(i);
        tableFull = 1'b0;
      end
      if (matchVec[i]) matchIdx = IDX_W'(i);
    end
  end
  assign matchHit = |matchVec;

  // address generator, loaded from the winning slot at stream start
  logic [ADDR_W-1:0] curAddrQ, stepQ;
  logic [LEN_W-1:0]  remainQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddrQ <= '0;
      stepQ    <= '0;
      remainQ  <= '0;
    end else if (strb.genStart) begin
      curAddrQ <= offArr[matchIdx] + ADDR_W'(1);
      stepQ    <= strArr[matchIdx] + ADDR_W'(1);
      remainQ  <= lenArr[matchIdx] - LEN_W'(1);
    end else if (strb.genStep && remainQ != '0) begin
      curAddrQ <= curAddrQ + stepQ;
      remainQ  <= remainQ - LEN_W'(1);
    end
  end

  assign specAddr = curAddrQ;
  assign lastElem = (remainQ == '0);

  // R2
  new_alloc_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.cmdNew |=> allocArr[$past(freeIdx)]);

  // R10
  free_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.doFree |=> !allocArr[$past(cmdIdx)]);

endmodule

// File: rtl/spt_ctrl.sv
module spt_ctrl
  import spt_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [2:0]       cmdOp,
  input  logic [IDX_W-1:0] freeIdx,
  input  logic             tableFull,
  input  logic             lkValid,
  input  logic             matchHit,
  input  logic             specReady,
  input  logic             lastElem,
  output strobe_t          strb,
  output logic             rspValid,
  output logic [IDX_W-1:0] rspIdx,
  output logic             rspErr,
  output logic             lkHit,
  output logic             lkMiss,
  output logic             genActive
);

  typedef enum logic {S_IDLE, S_GEN} state_e;
  state_e stateQ;

  logic lookupFire, genDone, opNew;

  assign lookupFire = lkValid && (stateQ == S_IDLE);
  assign opNew      = cmdValid && (cmdOp == OP_NEW);

  always_comb begin
    strb.genStart = lookupFire && matchHit;
    strb.genStep  = (stateQ == S_GEN) && specReady;
    strb.cmdNew   = opNew && !tableFull;
    strb.wrOff    = cmdValid && (cmdOp == OP_OFFSET);
    strb.wrLen    = cmdValid && (cmdOp == OP_LENGTH);
    strb.wrStr    = cmdValid && (cmdOp == OP_STRIDE);
    strb.doFree   = cmdValid && (cmdOp == OP_FREE);
  end
  assign genDone = strb.genStep && lastElem;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= S_IDLE;
      lkHit    <= 1'b0;
      lkMiss   <= 1'b0;
      rspValid <= 1'b0;
      rspIdx   <= '0;
      rspErr   <= 1'b0;
    end else begin
      lkHit    <= lookupFire && matchHit;
      lkMiss   <= lookupFire && !matchHit;
      rspValid <= opNew;
      rspIdx   <= freeIdx;
      rspErr   <= opNew && tableFull;
      case (stateQ)
        S_IDLE:  if (strb.genStart) stateQ <= S_GEN;
        S_GEN:   if (genDone) stateQ <= S_IDLE;
        default: stateQ <= S_IDLE;
      endcase
    end
  end

  assign genActive = (stateQ == S_GEN);

  // R7
  busy_refuse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lkValid && genActive) |=> (!lkHit && !lkMiss));

  // R7
  done_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (genActive && specReady && lastElem) |=> !genActive);

  // R4
  hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({lkHit, lkMiss}));

  // R4
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    lkMiss |-> !genActive);

endmodule

// File: rtl/stride_pattern_table.sv
module stride_pattern_table
  import spt_pkg::*;
#(
  parameter int  N_ENTRIES = 8,
  parameter int  ADDR_W    = 16,
  parameter int  LEN_W     = 8,
  localparam int IDX_W     = $clog2(N_ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [2:0]        cmdOp,
  input  logic [IDX_W-1:0]  cmdIdx,
  input  logic [ADDR_W-1:0] cmdData,
  output logic              rspValid,
  output logic [IDX_W-1:0]  rspIdx,
  output logic              rspErr,
  input  logic              lkValid,
  input  logic [ADDR_W-1:0] lkAddr,
  output logic              lkHit,
  output logic              lkMiss,
  output logic              busy,
  output logic              specValid,
  input  logic              specReady,
  output logic [ADDR_W-1:0] specAddr,
  output logic              specLast
);

  strobe_t          strb;
  logic [IDX_W-1:0] freeIdx;
  logic             tableFull, matchHit, lastElem, genActive;

  spt_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdValid  (cmdValid),
    .cmdOp     (cmdOp),
    .freeIdx   (freeIdx),
    .tableFull (tableFull),
    .lkValid   (lkValid),
    .matchHit  (matchHit),
    .specReady (specReady),
    .lastElem  (lastElem),
    .strb      (strb),
    .rspValid  (rspValid),
    .rspIdx    (rspIdx),
    .rspErr    (rspErr),
    .lkHit     (lkHit),
    .lkMiss    (lkMiss),
    .genActive (genActive)
  );

  spt_datapath #(
    .N_ENTRIES (N_ENTRIES),
    .ADDR_W    (ADDR_W),
    .LEN_W     (LEN_W),
    .IDX_W     (IDX_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .cmdIdx    (cmdIdx),
    .cmdData   (cmdData),
    .lkAddr    (lkAddr),
    .freeIdx   (freeIdx),
    .tableFull (tableFull),
    .matchHit  (matchHit),
    .specAddr  (specAddr),
    .lastElem  (lastElem)
  );

  assign busy      = genActive;
  assign specValid = genActive;
  assign specLast  = genActive && lastElem;

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (specValid && !specReady) |=> (specValid && $stable(specAddr)));

endmodule

// File: tb/sim_stride_pattern_table.sv
`timescale 1ns/1ps
module sim_stride_pattern_table;

  localparam int N = 8;
  localparam int AW = 16;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cmdValid = 1'b0;
  logic [2:0]    cmdOp = '0;
  logic [IW-1:0] cmdIdx = '0;
  logic [AW-1:0] cmdData = '0;
  logic          rspValid, rspErr, lkHit, lkMiss, busy, specValid, specLast;
  logic [IW-1:0] rspIdx;
  logic          lkValid = 1'b0;
  logic [AW-1:0] lkAddr = '0;
  logic          specReady = 1'b0;
  logic [AW-1:0] specAddr;

  stride_pattern_table u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdIdx(cmdIdx), .cmdData(cmdData), .rspValid(rspValid),
    .rspIdx(rspIdx), .rspErr(rspErr), .lkValid(lkValid), .lkAddr(lkAddr),
    .lkHit(lkHit), .lkMiss(lkMiss), .busy(busy), .specValid(specValid),
    .specReady(specReady), .specAddr(specAddr), .specLast(specLast)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // reference model of the table
  bit      mAlloc [N];
  bit      mHO [N], mHL [N], mHS [N];
  int      mOff [N], mLen [N], mStr [N];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int findFree();
    for (int i = 0; i < N; i++) if (!mAlloc[i]) return i;
    return -1;
  endfunction

  function automatic int findMatch(input int a);
    for (int i = 0; i < N; i++)
      if (mAlloc[i] && mHO[i] && mHL[i] && mHS[i] && mLen[i] != 0 && mOff[i] == a)
        return i;
    return -1;
  endfunction

  // issue one command and check the claim response where relevant
  task automatic issue(input int op, input int idx, input int data, output int got);
    int ef;
    ef = findFree();
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 3'(op); cmdIdx = IW'(idx); cmdData = AW'(data);
    @(posedge clk); #1;
    cmdValid = 1'b0;
    got = -1;
    if (op == 0) begin
      chk(rspValid == 1'b1, "R2 rspValid", rspValid, 1);
      if (ef < 0) begin
        chk(rspErr == 1'b1, "R2 full error", rspErr, 1);
      end else begin
        chk(rspErr == 1'b0 && int'(rspIdx) == ef, "R2 lowest free slot", rspIdx, ef);
        got = int'(rspIdx);
        mAlloc[ef] = 1; mHO[ef] = 0; mHL[ef] = 0; mHS[ef] = 0;
      end
    end else if (op == 4) begin
      mAlloc[idx] = 0; mHO[idx] = 0; mHL[idx] = 0; mHS[idx] = 0;
    end else if (op >= 1 && op <= 3 && mAlloc[idx]) begin
      if (op == 1) begin mOff[idx] = data & 16'hFFFF; mHO[idx] = 1; end
      if (op == 2) begin mLen[idx] = data & 8'hFF; mHL[idx] = 1; end
      if (op == 3) begin mStr[idx] = data & 16'hFFFF; mHS[idx] = 1; end
    end
  endtask

  task automatic define(input int off, input int len, input int str, output int slot);
    int d;
    issue(0, 0, 0, slot);
    issue(1, slot, off, d);
    issue(2, slot, len, d);
    issue(3, slot, str, d);
  endtask

  // lookup, then drain and check the whole stream
  task automatic lookup(input int a, input bit probe, input string tag);
    int e, k;
    bit probed;
    e = findMatch(a);
    @(negedge clk);
    lkValid = 1'b1; lkAddr = AW'(a);
    @(posedge clk); #1;
    lkValid = 1'b0;
    if (e < 0) begin
      chk(lkMiss == 1'b1 && lkHit == 1'b0, {tag, " miss"}, {lkHit, lkMiss}, 1);
      chk(specValid == 1'b0 && busy == 1'b0, {tag, " R4 quiet on miss"}, specValid, 0);
      return;
    end
    chk(lkHit == 1'b1 && lkMiss == 1'b0, {tag, " hit"}, {lkHit, lkMiss}, 2);
    chk(busy == 1'b1, {tag, " R7 busy on hit"}, busy, 1);
    k = 0;
    probed = 0;
    while (k < mLen[e]) begin
      @(negedge clk);
      if (probe && probed) begin
        chk(lkHit == 1'b0 && lkMiss == 1'b0, "R7 refused lookup", {lkHit, lkMiss}, 0);
        lkValid = 1'b0;
        probe = 0;
      end
      specReady = ($urandom % 3) != 0;
      chk(specValid == 1'b1, {tag, " R6 valid held"}, specValid, 1);
      chk(int'(specAddr) == ((mOff[e] + 1 + k * (mStr[e] + 1)) & 16'hFFFF),
          {tag, " R5 address"}, specAddr, (mOff[e] + 1 + k * (mStr[e] + 1)) & 16'hFFFF);
      if (specReady) begin
        chk(specLast == (k == mLen[e] - 1), {tag, " R5 last flag"}, specLast, k == mLen[e] - 1);
        k++;
      end
      if (probe && !probed) begin
        lkValid = 1'b1; lkAddr = AW'(a);
        probed = 1;
      end
    end
    @(negedge clk);
    specReady = 1'b0;
    lkValid = 1'b0;
    chk(specValid == 1'b0 && busy == 1'b0, {tag, " R7 idle after stream"}, busy, 0);
  endtask

  initial begin
    #1500000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int s, s2, d;
    void'($urandom(32'd20240607));
    for (int i = 0; i < N; i++) begin
      mAlloc[i] = 0; mHO[i] = 0; mHL[i] = 0; mHS[i] = 0;
      mOff[i] = 0; mLen[i] = 0; mStr[i] = 0;
    end
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(lkHit == 0 && lkMiss == 0 && busy == 0 && specValid == 0 &&
        specLast == 0 && rspValid == 0, "R1 reset outputs",
        {lkHit, lkMiss, busy, specValid, specLast, rspValid}, 0);
    lookup(0, 0, "R1 empty table");

    // R5 worked example: base 1, length 4, stride 2 -> 2,5,8,11
    define(1, 4, 2, s);
    lookup(1, 0, "R5 example");

    // R3 partial definition
    issue(0, 0, 0, s2);
    issue(1, s2, 20, d);
    issue(2, s2, 3, d);
    lookup(20, 0, "R3 partial");
    issue(3, s2, 0, d);
    lookup(20, 0, "R3 completed");

    // R8 duplicate trigger, lowest slot wins
    define(1, 2, 5, d);
    lookup(1, 0, "R8 duplicate");
    issue(4, s, 0, d);
    lookup(1, 0, "R10 freed, R8 next slot");

    // R9 zero length, R10 slot reuse
    define(50, 0, 1, d);
    chk(d == s, "R10 freed slot reused", d, s);
    lookup(50, 0, "R9 zero length");

    // R2 fill until full, then claim fails
    while (findFree() >= 0) issue(0, 0, 0, d);
    issue(0, 0, 0, d);

    // R11 writes to an unallocated slot are ignored
    issue(4, 3, 0, d);
    issue(1, 3, 77, d);
    issue(2, 3, 2, d);
    issue(3, 3, 1, d);
    lookup(77, 0, "R11 unallocated writes");
    issue(5, 3, 77, d);
    issue(0, 0, 0, d);
    chk(d == 3, "R10 released slot claimed", d, 3);
    lookup(77, 0, "R3 fields cleared on claim");

    // R7 lookup during a stream, R5 address wrap
    issue(1, 3, 16'hFFFE, d);
    issue(2, 3, 3, d);
    issue(3, 3, 0, d);
    lookup(16'hFFFE, 1, "R5 wrap R7 probe");

    // random phase
    for (int i = 0; i < N; i++) issue(4, i, 0, d);
    for (int it = 0; it < 400; it++) begin
      int op;
      op = $urandom % 6;
      case (op)
        0: issue(0, 0, 0, d);
        1: issue(1, $urandom % N, $urandom % 16, d);
        2: issue(2, $urandom % N, $urandom % 6, d);
        3: issue(3, $urandom % N, $urandom % 300, d);
        4: if (($urandom % 3) == 0) issue(4, $urandom % N, 0, d);
        default: lookup($urandom % 16, ($urandom % 4) == 0, "R4 random lookup");
      endcase
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule